// File: doc/BRIEF.md
# Byte-Assembling Host Write Shadow

This block joins an 8-bit host data bus to a bank of 32-bit internal registers. Each host write access places one byte into a persistent 32-bit staging word, the write shadow. The low two address bits pick the byte lane. The shadow is never cleared by use, so any byte that is not rewritten keeps whatever value it last held.

A commit copies the entire staging word into one destination register in a single clock. Six address bits select the destination. A commit happens when the top address bit is high during a write. When the auto-commit configuration input is set, a commit also happens on any write to the most significant byte lane. On a committing access, the byte being written is merged into the shadow first, and the merged word is what reaches the destination. Both the shadow update and the register update land on the same rising edge.

The destination write enable, index and word are brought out, and they also drive a small register bank modelled inside the block. The whole bank is presented as one flat output vector. Word indices at or above the implemented register count ignore the commit, but writes to those indices still update the shadow. The write strobe is a plain synchronous pulse with no back-pressure: the port accepts a write on every cycle in which the strobe is high.

Top module: `hws_top`

## Requirements
- R1: Synchronous reset clears the shadow and every register to zero. While reset is high, the destination write enable stays low, even if the strobe is high.
- R2: A write with address bit 8 low, and without auto-commit on lane 3, leaves the destination write enable low and leaves every register unchanged.
- R3: Address bits 1..0 select the shadow lane. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24. Each write changes exactly that one lane.
- R4: A write with address bit 8 high raises the destination write enable in the same cycle. The destination index equals address bits 7..2. The destination word equals the shadow with the current byte merged in. The addressed register holds that word after the rising edge.
- R5: A commit does not clear the shadow. Lanes not written since an earlier commit are copied again, with their old values, on the next commit.
- R6: Lanes may be written in any order and any number of times. Only the most recent byte written to each lane reaches the next commit.
- R7: A single write to address 0x14F updates register 19 (word offset 0x4C) in one access. The register receives the earlier shadow with its bits 31:24 replaced by the written byte.
- R8: With cfg_auto_commit high, a write to lane 3 commits even when address bit 8 is low, and writes to lanes 0..2 do not commit. With cfg_auto_commit low, a lane 3 write without address bit 8 does not commit.
- R9: A commit whose index is at or above NUM_REGS (default 32) does not raise the destination write enable and leaves all registers unchanged. The written byte still enters the shadow.
- R10: A commit changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_auto_commit | input | 1 | High: writes to lane 3 also commit |
| wr_stb | input | 1 | Write strobe, one access per high cycle |
| wr_addr | input | 9 | Bit 8 commit, bits 7..2 register index, bits 1..0 lane |
| wr_data | input | 8 | Byte to place in the selected lane |
| dest_we | output | 1 | Destination write enable, combinational in the access cycle |
| dest_idx | output | 6 | Destination register index |
| dest_word | output | 32 | Merged shadow word being committed |
| regs_flat | output | NUM_REGS*32 | Register bank, register i at bits i*32 +: 32 |

## Verification
The embedded properties assume that the inputs carry known values from the first clock after reset. They also assume that the configuration input changes only while the strobe is low, because the commit decode depends on it in the access cycle. The bench drives every input on the falling edge. It issues each write as a one-cycle strobe pulse and changes cfg_auto_commit only between accesses. It reads the combinational destination outputs before the rising edge and reads the register bank after it.

// File: rtl/hws_pkg.sv
package hws_pkg;
  localparam int unsigned HWS_DATA_W = 8;
  localparam int unsigned HWS_LANES  = 4;
  localparam int unsigned HWS_LANE_W = $clog2(HWS_LANES);
  localparam int unsigned HWS_IDX_W  = 6;
  localparam int unsigned HWS_WORD_W = HWS_DATA_W * HWS_LANES;
  localparam int unsigned HWS_ADDR_W = HWS_IDX_W + HWS_LANE_W + 1;

  typedef struct packed {
    logic                  commit;
    logic [HWS_IDX_W-1:0]  idx;
    logic [HWS_LANE_W-1:0] lane;
  } hws_addr_t;
endpackage

// File: rtl/hws_addr_decode.sv
module hws_addr_decode
  import hws_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                  auto_cfg,
  input  logic [HWS_ADDR_W-1:0] addr,
  output logic [HWS_LANE_W-1:0] lane,
  output logic [HWS_IDX_W-1:0]  idx,
  output logic                  commit_req,
  output logic                  in_range
);
  localparam logic [HWS_LANE_W-1:0] TOP_LANE = HWS_LANE_W'(HWS_LANES - 1);

  hws_addr_t fields;

  always_comb begin
    fields     = hws_addr_t'(addr);
    lane       = fields.lane;
    idx        = fields.idx;
    // explicit commit bit, or automatic commit on the most significant lane
    commit_req = fields.commit | (auto_cfg & (fields.lane == TOP_LANE));
    in_range   = (32'(fields.idx) < NUM_REGS);
  end
endmodule

// File: rtl/hws_shadow.sv
module hws_shadow
  import hws_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [HWS_LANE_W-1:0] lane,
  input  logic [HWS_DATA_W-1:0] data,
  output logic [HWS_WORD_W-1:0] merged,
  output logic [HWS_WORD_W-1:0] shadow_q
);
  // per-lane merge: the selected lane takes the bus byte, others keep the shadow
  for (genvar g = 0; g < HWS_LANES; g++) begin : g_lane
    always_comb begin
      if (lane == HWS_LANE_W'(g))
        merged[g*HWS_DATA_W +: HWS_DATA_W] = data;
      else
        merged[g*HWS_DATA_W +: HWS_DATA_W] = shadow_q[g*HWS_DATA_W +: HWS_DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        shadow_q <= '0;
    else if (wr_en) shadow_q <= merged;
  end

  a_r3_lane_written: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> HWS_DATA_W'(shadow_q >> {$past(lane), 3'b000}) == $past(data));

  a_r5_shadow_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(shadow_q));
endmodule

// File: rtl/hws_regfile.sv
module hws_regfile
  import hws_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [HWS_IDX_W-1:0]           idx,
  input  logic [HWS_WORD_W-1:0]          word,
  output logic [NUM_REGS*HWS_WORD_W-1:0] regs_flat
);
  logic [HWS_WORD_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)
        regs_q[i] <= '0;
      else if (we && (32'(idx) == i))
        regs_q[i] <= word;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_flat[g*HWS_WORD_W +: HWS_WORD_W] = regs_q[g];

    a_r10_other_regs_stable: assert property (@(posedge clk) disable iff (rst)
      !(we && (32'(idx) == g)) |=> $stable(regs_q[g]));

    a_r4_reg_takes_word: assert property (@(posedge clk) disable iff (rst)
      (we && (32'(idx) == g)) |=> regs_q[g] == $past(word));
  end
endmodule

// File: rtl/hws_top.sv
module hws_top
  import hws_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_auto_commit,
  input  logic                           wr_stb,
  input  logic [HWS_ADDR_W-1:0]          wr_addr,
  input  logic [HWS_DATA_W-1:0]          wr_data,
  output logic                           dest_we,
  output logic [HWS_IDX_W-1:0]           dest_idx,
  output logic [HWS_WORD_W-1:0]          dest_word,
  output logic [NUM_REGS*HWS_WORD_W-1:0] regs_flat
);
  logic [HWS_LANE_W-1:0] lane;
  logic [HWS_IDX_W-1:0]  idx;
  logic                  commit_req;
  logic                  in_range;
  logic [HWS_WORD_W-1:0] merged;
  logic [HWS_WORD_W-1:0] shadow_q;

  hws_addr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .auto_cfg   (cfg_auto_commit),
    .addr       (wr_addr),
    .lane       (lane),
    .idx        (idx),
    .commit_req (commit_req),
    .in_range   (in_range)
  );

  hws_shadow u_shadow (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_stb),
    .lane     (lane),
    .data     (wr_data),
    .merged   (merged),
    .shadow_q (shadow_q)
  );

  assign dest_we   = wr_stb & commit_req & in_range & ~rst;
  assign dest_idx  = idx;
  assign dest_word = merged;

  hws_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (dest_we),
    .idx       (dest_idx),
    .word      (dest_word),
    .regs_flat (regs_flat)
  );

  a_r1_no_commit_in_reset: assert property (@(posedge clk)
    rst |-> !dest_we);

  a_r9_index_in_range: assert property (@(posedge clk) disable iff (rst)
    dest_we |-> (32'(dest_idx) < NUM_REGS));

  a_r2_commit_needs_request: assert property (@(posedge clk) disable iff (rst)
    dest_we |-> (wr_stb && (wr_addr[HWS_ADDR_W-1] || cfg_auto_commit)));

  a_r4_commit_updates_shadow: assert property (@(posedge clk) disable iff (rst)
    dest_we |=> shadow_q == $past(dest_word));
endmodule

// File: tb/hws_top_tb.sv
module hws_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_auto_commit = 1'b0;
  logic wr_stb = 1'b0;
  logic [8:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic dest_we;
  logic [5:0] dest_idx;
  logic [31:0] dest_word;
  logic [NREG*32-1:0] regs_flat;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_shadow;
  logic [31:0] m_regs [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  hws_top #(.NUM_REGS(NREG)) u_dut (
    .clk(clk), .rst(rst), .cfg_auto_commit(cfg_auto_commit),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .dest_we(dest_we), .dest_idx(dest_idx), .dest_word(dest_word),
    .regs_flat(regs_flat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_of(input int i);
    return regs_flat[i*32 +: 32];
  endfunction

  task automatic chk_all_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, reg_of(i), m_regs[i]);
  endtask

  // one access: drive at negedge, check combinational outputs, then bank after edge
  task automatic hw_write(input logic [8:0] a, input logic [7:0] d, input string req);
    logic [31:0] merged;
    logic commit;
    logic exp_we;
    merged = m_shadow;
    merged[a[1:0]*8 +: 8] = d;
    commit = a[8] | (cfg_auto_commit & (a[1:0] == 2'd3));
    exp_we = commit & (int'(a[7:2]) < NREG);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    #1;
    chk({req, " we"}, 32'(dest_we), 32'(exp_we));
    if (exp_we) begin
      chk({req, " idx"}, 32'(dest_idx), 32'(a[7:2]));
      chk({req, " word"}, dest_word, merged);
    end
    @(negedge clk);
    wr_stb = 1'b0;
    m_shadow = merged;
    if (exp_we) m_regs[a[7:2]] = merged;
  endtask

  task automatic t_reset;
    // R1: strobe with commit during reset must not write
    @(negedge clk);
    rst = 1'b1; wr_addr = 9'h104; wr_data = 8'hEE; wr_stb = 1'b1;
    #1 chk("R1 we in reset", 32'(dest_we), 0);
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    m_shadow = '0;
    for (int i = 0; i < NREG; i++) m_regs[i] = '0;
    chk_all_regs("R1 regs zero");
    hw_write(9'h108, 8'h00, "R1 shadow zero");
    chk("R1 shadow cleared", reg_of(2), 32'h0);
  endtask

  task automatic t_lanes;
    hw_write(9'h004, 8'h11, "R2 lane0");
    hw_write(9'h005, 8'h22, "R2 lane1");
    hw_write(9'h006, 8'h33, "R2 lane2");
    hw_write(9'h007, 8'h44, "R2 lane3");
    chk_all_regs("R2 no change");
    hw_write(9'h104, 8'h55, "R4 commit");
    chk("R3 R4 reg1", reg_of(1), 32'h44332255);
    chk_all_regs("R10 others");
  endtask

  task automatic t_stale;
    hw_write(9'h109, 8'h99, "R5 commit");
    chk("R5 stale lanes", reg_of(2), 32'h44339955);
    chk("R5 reg1 kept", reg_of(1), 32'h44332255);
  endtask

  task automatic t_order;
    hw_write(9'h00F, 8'hA1, "R6 w3");
    hw_write(9'h00C, 8'hB2, "R6 w0");
    hw_write(9'h00F, 8'hC3, "R6 w3b");
    hw_write(9'h00D, 8'hD4, "R6 w1");
    hw_write(9'h10E, 8'hE5, "R6 commit");
    chk("R6 order", reg_of(3), 32'hC3E5D4B2);
    chk_all_regs("R10 after R6");
  endtask

  task automatic t_example;
    hw_write(9'h14F, 8'h5A, "R7 single");
    chk("R7 reg19", reg_of(19), 32'h5AE5D4B2);
    chk_all_regs("R10 after R7");
  endtask

  task automatic t_auto;
    @(negedge clk) cfg_auto_commit = 1'b1;
    hw_write(9'h014, 8'h01, "R8 auto l0");
    hw_write(9'h015, 8'h02, "R8 auto l1");
    hw_write(9'h016, 8'h03, "R8 auto l2");
    chk("R8 no early", reg_of(5), 32'h0);
    hw_write(9'h017, 8'h04, "R8 auto l3");
    chk("R8 auto reg5", reg_of(5), 32'h04030201);
    @(negedge clk) cfg_auto_commit = 1'b0;
    hw_write(9'h01B, 8'h77, "R8 off l3");
    chk("R8 off reg6", reg_of(6), 32'h0);
    chk_all_regs("R8 all");
  endtask

  task automatic t_range;
    hw_write(9'h1A0, 8'h66, "R9 idx40");
    chk_all_regs("R9 unchanged");
    hw_write(9'h1FD, 8'h88, "R9 idx63");
    chk_all_regs("R9 unchanged 63");
    hw_write(9'h118, 8'h66, "R9 idx6");
    chk("R9 shadow kept", reg_of(6), 32'h77038866);
  endtask

  task automatic finish_report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_lanes();
    t_stale();
    t_order();
    t_example();
    t_auto();
    t_range();
    repeat (2) @(negedge clk);
    finish_report();
  end
endmodule